// File: doc/BRIEF.md
# Three-Port General Register Bank

This block holds the working operands of a pipelined datapath: thirty-two words of thirty-two bits each. In one clock cycle it serves two independent read lookups and one write. The reads are purely combinational, so an operand is available within the cycle in which its index is presented. The write commits on the rising clock edge.

Each read lookup has its own enable. While a lookup is disabled, its port drives a fixed idle word and clears its valid flag. Entry 0 is a constant zero: writes aimed at it are discarded. Any write to a nonzero entry is forwarded to a reader that asks for the same entry in the same cycle. A reader therefore sees a value in the same cycle it is written back, without waiting for the edge. A synchronous active-high reset clears every entry.

Top module: `gpr_bank`

## Requirements
- R1: Both read lookups and the write operate in the same cycle without interfering: each lookup returns the data of its own index while a write to a third index commits.
- R2: An entry changes only on a rising clock edge with `wr_en` high; with `wr_en` low the entries keep their values across edges.
- R3: A write changes exactly the entry named by `wr_idx`; every other entry keeps its value.
- R4: Read data follows a change of the read index within the same cycle, with no clock edge in between.
- R5: Entry 0 always reads as 32'h0000_0000, and a write with `wr_idx` = 0 changes nothing.
- R6: When a lookup is enabled and its index equals a nonzero `wr_idx` while `wr_en` is high, the lookup returns `wr_data` before the edge. No forwarding takes place for index 0.
- R7: A disabled lookup drives 32'hFFFF_FFFF on its data output with valid = 0. An enabled lookup drives valid = 1.
- R8: With `rst` high at a rising edge, every entry is cleared to zero.
- R9: Two enabled lookups on the same index return identical data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Entry to write |
| wr_data | input | 32 | Word to write |
| rd_a_en | input | 1 | Lookup A enable |
| rd_a_idx | input | 5 | Lookup A entry index |
| rd_a_data | output | 32 | Lookup A word or idle word |
| rd_a_valid | output | 1 | Lookup A data is meaningful |
| rd_b_en | input | 1 | Lookup B enable |
| rd_b_idx | input | 5 | Lookup B entry index |
| rd_b_data | output | 32 | Lookup B word or idle word |
| rd_b_valid | output | 1 | Lookup B data is meaningful |

## Verification
After reset, every entry is read back through both lookups; this catches a clear that misses any entry. The bank is then filled with an index-dependent pattern and read back in full, which exposes decoder aliasing (two entries receiving one write) and any leak into entry 0. Cycles that present a write alongside lookups of the same entry, of a different entry, and of entry 0 separate correct forwarding from stale reads and from forwarding wrongly applied to zero. Toggling the enables and the write request with no other change tells the idle behaviour apart from the read behaviour, and separates a real write from a write that should have been ignored.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    parameter int NREGS = 32;
    parameter int XLEN  = 32;
    localparam int IDX_W = $clog2(NREGS);
    localparam logic [XLEN-1:0] IDLE_WORD = {XLEN{1'b1}};

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [XLEN-1:0]  word_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } wr_req_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
    } rd_req_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } rd_rsp_t;

    function automatic logic idx_is_zero(input idx_t i);
        return ~|i;
    endfunction
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode
    import gpr_pkg::*;
(
    input  wr_req_t          req,
    output logic [NREGS-1:0] sel
);
    logic live;
    assign live = req.en & ~idx_is_zero(req.idx);

    for (genvar i = 0; i < NREGS; i++) begin : g_sel
        if (i == 0) begin : g_zero
            assign sel[i] = 1'b0;
        end else begin : g_live
            assign sel[i] = live && (req.idx == idx_t'(i));
        end
    end
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage
    import gpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NREGS-1:0] sel,
    input  word_t            data,
    output word_t            regs [NREGS]
);
    for (genvar i = 0; i < NREGS; i++) begin : g_ent
        if (i == 0) begin : g_const
            assign regs[i] = '0;
        end else begin : g_flop
            word_t q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (sel[i])
                    q <= data;
            end
            assign regs[i] = q;
        end
    end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
    import gpr_pkg::*;
(
    input  rd_req_t req,
    input  wr_req_t wr,
    input  word_t   regs [NREGS],
    output rd_rsp_t rsp
);
    logic fwd;
    assign fwd = wr.en && !idx_is_zero(wr.idx) && (wr.idx == req.idx);

    always_comb begin
        if (!req.en) begin
            rsp.valid = 1'b0;
            rsp.data  = IDLE_WORD;
        end else begin
            rsp.valid = 1'b1;
            if (idx_is_zero(req.idx))
                rsp.data = '0;
            else if (fwd)
                rsp.data = wr.data;
            else
                rsp.data = regs[req.idx];
        end
    end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [4:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  logic        rd_a_en,
    input  logic [4:0]  rd_a_idx,
    output logic [31:0] rd_a_data,
    output logic        rd_a_valid,
    input  logic        rd_b_en,
    input  logic [4:0]  rd_b_idx,
    output logic [31:0] rd_b_data,
    output logic        rd_b_valid
);
    localparam int NPORTS = 2;

    wr_req_t          wr;
    logic [NREGS-1:0] sel;
    word_t            regs [NREGS];
    rd_req_t          rq [NPORTS];
    rd_rsp_t          rs [NPORTS];

    assign wr = '{en: wr_en, idx: wr_idx, data: wr_data};
    assign rq[0] = '{en: rd_a_en, idx: rd_a_idx};
    assign rq[1] = '{en: rd_b_en, idx: rd_b_idx};

    gpr_wr_decode u_dec (.req(wr), .sel(sel));

    gpr_storage u_mem (
        .clk  (clk),
        .rst  (rst),
        .sel  (sel),
        .data (wr.data),
        .regs (regs)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        gpr_read_port u_rp (
            .req  (rq[p]),
            .wr   (wr),
            .regs (regs),
            .rsp  (rs[p])
        );
    end

    assign rd_a_data  = rs[0].data;
    assign rd_a_valid = rs[0].valid;
    assign rd_b_data  = rs[1].data;
    assign rd_b_valid = rs[1].valid;
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk
    import gpr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        rd_a_en,
    input logic [4:0]  rd_a_idx,
    input logic [31:0] rd_a_data,
    input logic        rd_a_valid,
    input logic        rd_b_en,
    input logic [4:0]  rd_b_idx,
    input logic [31:0] rd_b_data,
    input logic        rd_b_valid
);
    AST_ZERO_ENTRY_A: assert property (@(posedge clk) disable iff (rst)
        (rd_a_en && rd_a_idx == 5'd0) |-> rd_a_data == 32'd0); // R5
    AST_ZERO_ENTRY_B: assert property (@(posedge clk) disable iff (rst)
        (rd_b_en && rd_b_idx == 5'd0) |-> rd_b_data == 32'd0); // R5
    AST_IDLE_A: assert property (@(posedge clk) disable iff (rst)
        !rd_a_en |-> (!rd_a_valid && rd_a_data == IDLE_WORD)); // R7
    AST_IDLE_B: assert property (@(posedge clk) disable iff (rst)
        !rd_b_en |-> (!rd_b_valid && rd_b_data == IDLE_WORD)); // R7
    AST_VALID_A: assert property (@(posedge clk) disable iff (rst)
        rd_a_en |-> rd_a_valid); // R7
    AST_FWD_A: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != 5'd0 && rd_a_en && rd_a_idx == wr_idx)
        |-> rd_a_data == wr_data); // R6
    AST_FWD_B: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != 5'd0 && rd_b_en && rd_b_idx == wr_idx)
        |-> rd_b_data == wr_data); // R6
    AST_SAME_IDX: assert property (@(posedge clk) disable iff (rst)
        (rd_a_en && rd_b_en && rd_a_idx == rd_b_idx)
        |-> rd_a_data == rd_b_data); // R9
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != 5'd0)
        |=> (!(rd_a_en && rd_a_idx == $past(wr_idx))
             || (wr_en && wr_idx == rd_a_idx)
             || rd_a_data == $past(wr_data))); // R2
endmodule

bind gpr_bank gpr_bank_chk i_chk (.*);

// File: tb/test_gpr_bank.sv
module test_gpr_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;
    logic        rd_a_en, rd_b_en;
    logic [4:0]  rd_a_idx, rd_b_idx;
    logic [31:0] rd_a_data, rd_b_data;
    logic        rd_a_valid, rd_b_valid;

    logic [31:0] model [32];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpr_bank i_gpr_bank (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(posedge clk);
        if (idx != 5'd0) model[idx] = d;
        #1 wr_en = 1'b0;
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            rd_a_en = 1'b1; rd_a_idx = 5'(i);
            rd_b_en = 1'b1; rd_b_idx = 5'(31 - i);
            #2;
            check(req, rd_a_data, model[i]);
            check(req, rd_b_data, model[31 - i]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = 32'd0;
    endtask

    task automatic t_reset_clear();     // R8
        read_all("R8");
    endtask

    task automatic t_fill();            // R3 R5
        for (int i = 0; i < 32; i++)
            do_write(5'(i), 32'hA5000000 ^ (32'(i) * 32'h00010203) ^ 32'(i));
        read_all("R3");
        check("R5", model[0], 32'd0);
    endtask

    task automatic t_single_write();    // R3
        do_write(5'd12, 32'h0C0C_1212);
        read_all("R3");
    endtask

    task automatic t_no_enable();       // R2
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 5'd5; wr_data = 32'h5555_AAAA;
        @(posedge clk);
        @(negedge clk);
        rd_a_en = 1'b1; rd_a_idx = 5'd5;
        #2 check("R2", rd_a_data, model[5]);
    endtask

    task automatic t_forward();         // R6 R5
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd7; wr_data = 32'h7777_0001;
        rd_a_en = 1'b1; rd_a_idx = 5'd7;
        rd_b_en = 1'b1; rd_b_idx = 5'd8;
        #2;
        check("R6", rd_a_data, 32'h7777_0001);
        check("R6", rd_b_data, model[8]);
        @(posedge clk);
        model[7] = 32'h7777_0001;
        #1 wr_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd0; wr_data = 32'hDEAD_0000;
        rd_a_idx = 5'd0;
        #2 check("R6", rd_a_data, 32'd0);
        @(posedge clk);
        #1 wr_en = 1'b0;
        @(negedge clk);
        #2 check("R5", rd_a_data, 32'd0);
        rd_b_idx = 5'd7;
        #1 check("R6", rd_b_data, 32'h7777_0001);
    endtask

    task automatic t_comb_read();       // R4
        @(negedge clk);
        rd_a_en = 1'b1;
        for (int i = 3; i < 7; i++) begin
            rd_a_idx = 5'(i);
            #1 check("R4", rd_a_data, model[i]);
        end
    endtask

    task automatic t_idle();            // R7
        @(negedge clk);
        rd_a_en = 1'b0; rd_b_en = 1'b0;
        wr_en = 1'b1; wr_idx = 5'd20; wr_data = 32'h2020_2020;
        rd_a_idx = 5'd20;
        #2;
        check("R7", rd_a_data, 32'hFFFF_FFFF);
        check("R7", 32'(rd_a_valid), 32'd0);
        check("R7", rd_b_data, 32'hFFFF_FFFF);
        check("R7", 32'(rd_b_valid), 32'd0);
        @(posedge clk);
        model[20] = 32'h2020_2020;
        #1 wr_en = 1'b0;
        @(negedge clk);
        rd_a_en = 1'b1;
        #2;
        check("R7", 32'(rd_a_valid), 32'd1);
        check("R7", rd_a_data, model[20]);
    endtask

    task automatic t_three_way();       // R1 R9
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'h9999_1111;
        rd_a_en = 1'b1; rd_a_idx = 5'd3;
        rd_b_en = 1'b1; rd_b_idx = 5'd4;
        #2;
        check("R1", rd_a_data, model[3]);
        check("R1", rd_b_data, model[4]);
        @(posedge clk);
        model[9] = 32'h9999_1111;
        #1 wr_en = 1'b0;
        @(negedge clk);
        rd_a_idx = 5'd9; rd_b_idx = 5'd9;
        #2;
        check("R1", rd_a_data, 32'h9999_1111);
        check("R9", rd_b_data, rd_a_data);
        check("R9", rd_b_data, model[9]);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        rd_a_en = 1'b0; rd_a_idx = '0; rd_b_en = 1'b0; rd_b_idx = '0;
        for (int i = 0; i < 32; i++) model[i] = 32'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset_clear();
        t_fill();
        t_single_write();
        t_no_enable();
        t_forward();
        t_comb_read();
        t_idle();
        t_three_way();
        do_reset();
        t_reset_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule